// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block divides a fast oscillator clock by a programmable integer modulus and emits one narrow pulse per division period, for use as the feedback input of a phase detector. All of its logic runs on the fast clock. Only a small prescaler counter has to change state on nearly every edge. The prescaler alternates between dividing by four and dividing by five. Two slower counters, a main counter and a swallow counter, decide how many five-cycle groups and how many four-cycle groups make up each period. With these prescaler moduli the total modulus T equals 4*M + A. Here M is the total number of prescaler cycles and A, the swallow count, is the number of those cycles that last five clocks.

The requested modulus is a 9-bit unsigned value. Before use it is clamped into the legal range 37 to 448. A doubling control bit then doubles the clamped modulus, which extends the range to the even values 74 to 896. The block derives M and A from the effective modulus on its own. A new request takes effect only when the current period ends, so every period uses a single, consistent modulus.

Top module: `dual_mod_divider`

## Requirements
- R1: With `dblEn` low and `modReq` in 37..448, successive `divPulse` pulses are exactly `modReq` clock cycles apart.
- R2: With `dblEn` high, the period is twice the clamped `modReq`, so every even value from 74 to 896 can be reached.
- R3: A `modReq` below 37 is treated as 37, and one above 448 is treated as 448. Clamping happens before doubling.
- R4: Each period consists of M = T div 4 prescaler cycles. The first A = T mod 4 of these last five clocks and the rest last four, and the swallow count never exceeds the number of prescaler cycles still to run.
- R5: A change of `modReq` or `dblEn` has no effect on the period in progress. The values present in the last cycle of a period, the cycle in which `termCount` is high, set the length of the next period.
- R6: `termCount` is high for exactly one clock cycle, the last cycle of each period, and is low while `rst` is high.
- R7: `divPulse` is a single-cycle high pulse in the cycle that follows each `termCount` cycle.
- R8: `rst` is synchronous. While it is high, `divPulse` is low, and the modulus present during reset is loaded. The first `divPulse` after release is seen T rising edges after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| modReq | input | 9 | Requested modulus before clamping |
| dblEn | input | 1 | Doubles the clamped modulus when high |
| termCount | output | 1 | High during the last clock cycle of each period |
| divPulse | output | 1 | One-cycle pulse, registered, once per period |

## Verification
The assertions assume that `modReq` and `dblEn` are synchronous to `clk` and change only between edges. They also assume that `rst` is held high for at least one rising edge before the divider is expected to count. The period-length checker relies on the clamp, which keeps every period at 37 cycles or more, so the single-cycle properties on `termCount` and `divPulse` can never see two terminal counts in a row. The stimulus changes every input on the falling edge and holds reset for three rising edges. Mid-period changes are applied both well inside a period and in the exact terminal-count cycle.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  // Strobes issued by the fast control stage to the counter datapath.
  typedef struct packed {
    logic reload;   // start a new period from the mapped counts
    logic preTick;  // one prescaler cycle has completed
  } dmd_strobe_t;

  // Status returned by the datapath to the control stage.
  typedef struct packed {
    logic mainLast;  // the current prescaler cycle is the final one of the period
    logic nextFive;  // the next prescaler cycle must last PRE_LO+1 clocks
  } dmd_status_t;

endpackage

// File: rtl/dmd_modulus_map.sv
module dmd_modulus_map #(
  parameter int MOD_W   = 9,
  parameter int MOD_MIN = 37,
  parameter int MOD_MAX = 448,
  parameter int PRE_W   = 2,
  parameter int EFF_W   = MOD_W + 1,
  parameter int M_W     = EFF_W - PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] modReq,
  input  logic             dblEn,
  output logic [EFF_W-1:0] effMod,
  output logic [M_W-1:0]   mainCnt,
  output logic [PRE_W-1:0] swallowCnt
);

  localparam logic [MOD_W-1:0] MinVal = MOD_W'(MOD_MIN);
  localparam logic [MOD_W-1:0] MaxVal = MOD_W'(MOD_MAX);

  logic [MOD_W-1:0] clampedMod;

  always_comb begin
    if (modReq < MinVal)      clampedMod = MinVal;
    else if (modReq > MaxVal) clampedMod = MaxVal;
    else                      clampedMod = modReq;
  end

  // Doubling is a one-bit left shift of the clamped request.
  always_comb begin
    if (dblEn) effMod = {clampedMod, 1'b0};
    else       effMod = {1'b0, clampedMod};
  end

  // Prescaler low modulus is a power of two: quotient and remainder are bit slices.
  assign mainCnt    = effMod[EFF_W-1:PRE_W];
  assign swallowCnt = effMod[PRE_W-1:0];

  // R3: effective modulus always lies in the legal window for the current mode.
  assert_clamp_range_R3: assert property (@(posedge clk) disable iff (rst)
    (effMod >= EFF_W'(MOD_MIN)) &&
    (effMod <= (dblEn ? EFF_W'(2 * MOD_MAX) : EFF_W'(MOD_MAX))));

endmodule

// File: rtl/dmd_datapath.sv
module dmd_datapath
  import dmd_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int M_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dmd_strobe_t      strb,
  input  logic [M_W-1:0]   mLoad,
  input  logic [PRE_W-1:0] aLoad,
  output dmd_status_t      status
);

  logic [M_W-1:0]   mainLeft;
  logic [PRE_W-1:0] swLeft;

  // Slow counters: they move only on reload or on a prescaler tick.
  always_ff @(posedge clk) begin
    if (strb.reload) begin
      mainLeft <= mLoad;
      swLeft   <= aLoad;
    end else if (strb.preTick) begin
      mainLeft <= mainLeft - M_W'(1);
      if (swLeft != '0) swLeft <= swLeft - PRE_W'(1);
    end
  end

  always_comb begin
    status.mainLast = (mainLeft == M_W'(1));
    if (strb.reload)       status.nextFive = (aLoad != '0);
    else if (strb.preTick) status.nextFive = (swLeft > PRE_W'(1));
    else                   status.nextFive = (swLeft != '0);
  end

  // R4: swallow cycles never outnumber the prescaler cycles left in the period.
  assert_swallow_bound_R4: assert property (@(posedge clk) disable iff (rst)
    M_W'(swLeft) <= mainLeft);

  // R4: the main counter never reaches zero inside a period.
  assert_main_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    mainLeft != '0);

endmodule

// File: rtl/dmd_control.sv
module dmd_control
  import dmd_pkg::*;
#(
  parameter int PRE_LO = 4,
  parameter int CNT_W  = $clog2(PRE_LO + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  dmd_status_t status,
  output dmd_strobe_t strb,
  output logic        termCount,
  output logic        divPulse
);

  localparam logic [CNT_W-1:0] LoadFive = CNT_W'(PRE_LO);
  localparam logic [CNT_W-1:0] LoadFour = CNT_W'(PRE_LO - 1);

  logic [CNT_W-1:0] preCnt;
  logic             preTick;
  logic             tcHit;

  assign preTick = (preCnt == '0);
  assign tcHit   = preTick && status.mainLast && !rst;

  always_comb begin
    strb.preTick = preTick;
    strb.reload  = rst || tcHit;
  end

  // Fast two-modulus prescaler: counts down from PRE_LO or PRE_LO-1.
  always_ff @(posedge clk) begin
    if (strb.reload || preTick) preCnt <= status.nextFive ? LoadFive : LoadFour;
    else                        preCnt <= preCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) divPulse <= 1'b0;
    else     divPulse <= tcHit;
  end

  assign termCount = tcHit;

  // R4: prescaler count stays within the five-cycle window.
  assert_precnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    preCnt <= LoadFive);

  // R6: terminal count lasts one cycle.
  assert_tc_single_R6: assert property (@(posedge clk) disable iff (rst)
    termCount |=> !termCount);

  // R7: output pulse lasts one cycle.
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R8: output is low after any reset edge.
  assert_pulse_low_reset_R8: assert property (@(posedge clk)
    rst |=> !divPulse);

endmodule

// File: rtl/dual_mod_divider.sv
module dual_mod_divider
  import dmd_pkg::*;
#(
  parameter int MOD_W   = 9,
  parameter int MOD_MIN = 37,
  parameter int MOD_MAX = 448,
  parameter int PRE_LO  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MOD_W-1:0] modReq,
  input  logic             dblEn,
  output logic             termCount,
  output logic             divPulse
);

  localparam int PRE_W = $clog2(PRE_LO);
  localparam int EFF_W = MOD_W + 1;
  localparam int M_W   = EFF_W - PRE_W;
  localparam int CNT_W = $clog2(PRE_LO + 1);

  logic [EFF_W-1:0] effMod;
  logic [M_W-1:0]   mainCnt;
  logic [PRE_W-1:0] swallowCnt;
  dmd_strobe_t      strb;
  dmd_status_t      status;

  dmd_modulus_map #(
    .MOD_W(MOD_W), .MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX),
    .PRE_W(PRE_W), .EFF_W(EFF_W), .M_W(M_W)
  ) u_map (
    .clk(clk), .rst(rst), .modReq(modReq), .dblEn(dblEn),
    .effMod(effMod), .mainCnt(mainCnt), .swallowCnt(swallowCnt)
  );

  dmd_datapath #(.PRE_W(PRE_W), .M_W(M_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .mLoad(mainCnt), .aLoad(swallowCnt), .status(status)
  );

  dmd_control #(.PRE_LO(PRE_LO), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .status(status), .strb(strb),
    .termCount(termCount), .divPulse(divPulse)
  );

  // Period checker: counts cycles since the last reload against the latched modulus.
  logic [EFF_W:0]   periodCnt;
  logic [EFF_W-1:0] expMod;

  always_ff @(posedge clk) begin
    if (rst || termCount) begin
      periodCnt <= (EFF_W + 1)'(1);
      expMod    <= effMod;
    end else begin
      periodCnt <= periodCnt + (EFF_W + 1)'(1);
    end
  end

  // R1 / R2 / R5: each period lasts the modulus latched at its start.
  assert_period_len_R1: assert property (@(posedge clk) disable iff (rst)
    termCount |-> (periodCnt == {1'b0, expMod}));

endmodule

// File: tb/dual_mod_divider_bench.sv
`timescale 1ns/1ps
module dual_mod_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] modReq = 9'd37;
  logic       dblEn = 1'b0;
  logic       termCount;
  logic       divPulse;

  always #4 clk = ~clk;

  dual_mod_divider u_dual_mod_divider (
    .clk(clk), .rst(rst), .modReq(modReq), .dblEn(dblEn),
    .termCount(termCount), .divPulse(divPulse)
  );

  typedef struct packed {
    logic [8:0] req;
    logic       dbl;
    logic [9:0] per;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{9'd37,  1'b0, 10'd37},
    '{9'd38,  1'b0, 10'd38},
    '{9'd39,  1'b0, 10'd39},
    '{9'd40,  1'b0, 10'd40},
    '{9'd101, 1'b0, 10'd101},
    '{9'd255, 1'b0, 10'd255},
    '{9'd447, 1'b0, 10'd447},
    '{9'd448, 1'b0, 10'd448},
    '{9'd10,  1'b0, 10'd37},
    '{9'd0,   1'b0, 10'd37},
    '{9'd500, 1'b0, 10'd448},
    '{9'd37,  1'b1, 10'd74},
    '{9'd301, 1'b1, 10'd602},
    '{9'd448, 1'b1, 10'd896},
    '{9'd511, 1'b1, 10'd896},
    '{9'd5,   1'b1, 10'd74}
  };

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Counts rising edges until divPulse is seen at a falling edge; reports termCount one cycle earlier.
  task automatic waitPulse(output int n, output bit tcBefore);
    bit tcPrev;
    tcPrev = termCount;
    n = 0;
    tcBefore = 1'b0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (divPulse) begin
        tcBefore = tcPrev;
        break;
      end
      tcPrev = termCount;
      if (n > 2000) break;
    end
  endtask

  task automatic applyReset(input logic [8:0] req, input logic dbl);
    @(negedge clk);
    rst = 1'b1;
    modReq = req;
    dblEn = dbl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(divPulse == 1'b0, "R8 divPulse in reset", int'(divPulse), 0);
    check(termCount == 1'b0, "R6 termCount in reset", int'(termCount), 0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int n;
    bit tb;
    string tag;

    // Vector sweep over normal, clamped and doubled moduli.
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].req < 9'd37 || VECS[i].req > 9'd448) tag = "R3";
      else if (VECS[i].dbl)                            tag = "R2";
      else                                             tag = "R1";
      applyReset(VECS[i].req, VECS[i].dbl);
      waitPulse(n, tb);
      check(n == int'(VECS[i].per), $sformatf("R8 first latency req=%0d", VECS[i].req), n, int'(VECS[i].per));
      check(tb, "R7 pulse follows termCount", int'(tb), 1);
      waitPulse(n, tb);
      check(n == int'(VECS[i].per), $sformatf("%s/R4 period req=%0d dbl=%0d", tag, VECS[i].req, VECS[i].dbl),
            n, int'(VECS[i].per));
      waitPulse(n, tb);
      check(n == int'(VECS[i].per), $sformatf("%s repeat period req=%0d", tag, VECS[i].req), n, int'(VECS[i].per));
    end

    // R5: change requested well inside a period.
    applyReset(9'd50, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    modReq = 9'd60;
    waitPulse(n, tb);
    check(n == 40, "R5 current period unchanged", n, 40);
    waitPulse(n, tb);
    check(n == 60, "R5 new modulus next period", n, 60);

    // R6: termCount sits in the last cycle; R5: change in that very cycle applies next.
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!termCount && n < 2000);
    check(n == 59, "R6 termCount position", n, 59);
    modReq = 9'd70;
    waitPulse(n, tb);
    check(n == 1, "R7 pulse one cycle after termCount", n, 1);
    waitPulse(n, tb);
    check(n == 70, "R5 change at terminal count", n, 70);

    // R5 / R2: doubling switched mid-period.
    dblEn = 1'b1;
    waitPulse(n, tb);
    check(n == 70, "R5 doubling deferred", n, 70);
    waitPulse(n, tb);
    check(n == 140, "R2 doubled period", n, 140);

    // R8: reset asserted mid-run keeps outputs low.
    repeat (20) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(divPulse == 1'b0, "R8 divPulse low mid-run reset", int'(divPulse), 0);
      check(termCount == 1'b0, "R6 termCount low in reset", int'(termCount), 0);
    end
    modReq = 9'd41;
    dblEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    waitPulse(n, tb);
    check(n == 41, "R8 reload after mid-run reset", n, 41);

    finishRun();
  end

endmodule